// File: doc/BRIEF.md
# Link-Side Receive Decoder

This block sits on the link side of a PHY-to-link interface and follows each receive operation the PHY announces. On every system clock it samples a 2-bit control bus and an 8-bit data bus. When the control bus shows the receive code, the decoder skips any data-on preamble bytes. It reads the packet speed from the first byte that is not a data-on byte, and then forwards the remaining bytes as payload, marking the first and the last.

Receive operations that carry only preamble are reported as null packets. If the speed byte is not a legal code, or names a speed faster than the link is built for, the decoder raises a drop pulse and discards the rest of that operation. A parameter sets the fastest speed the link accepts. All outputs are registered, so each one appears one clock after the input cycle that caused it.

Top module: `link_rx_decoder`

## Requirements
- R1: A synchronous active-low reset clears every output on the next clock, sets `rxSpeed` to 0, and returns the decoder to waiting for a receive code, including when reset arrives in the middle of a packet.
- R2: A receive operation starts on the first cycle whose control value is 10. It may follow an idle cycle (00) or directly follow a status cycle (01).
- R3: During a receive operation, any byte whose bit 7 is 1 before the speed byte is a data-on byte. Any number of them in a row are skipped and produce no output.
- R4: The first receive byte with bit 7 equal to 0 is the speed byte. 00xxxxxx decodes to S100 (code 0), 0100xxxx to S200 (code 1), and exactly 01010000 to S400 (code 2), ignoring the x bits. An accepted code appears on `rxSpeed` one clock after the speed byte and holds until the next accepted speed byte. The speed byte itself is never output as data.
- R5: Each receive byte after an accepted speed byte appears on `rxData` with `rxValid` high one clock later, whatever its bit 7. `rxSop` is high with the first of these bytes only. `rxData` is 0 whenever `rxValid` is low.
- R6: The first non-receive cycle after an accepted speed byte produces a one-cycle `rxEop` pulse one clock later. This also happens when the packet had no payload bytes.
- R7: A receive operation that ends after only data-on bytes produces a one-cycle `nullPkt` pulse one clock after the first non-receive cycle, and no data.
- R8: A speed byte that matches none of the R4 patterns produces a one-cycle `rxDrop` pulse one clock later. The later bytes of that operation give no `rxValid`, and its end gives no `rxEop`. `rxSpeed` is left unchanged.
- R9: A legal speed code greater than parameter MAX_SPEED (0=S100, 1=S200, 2=S400) is handled exactly as in R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Synchronous active-low reset |
| ctlIn | input | 2 | Control bus: 00 idle, 01 status, 10 receive |
| dataIn | input | 8 | Data bus from the PHY |
| rxValid | output | 1 | Payload byte valid on rxData |
| rxData | output | 8 | Payload byte |
| rxSop | output | 1 | First payload byte of a packet |
| rxEop | output | 1 | One-cycle end pulse of an accepted packet |
| rxSpeed | output | 2 | Speed of the current packet (0, 1, 2) |
| nullPkt | output | 1 | One-cycle pulse for a preamble-only operation |
| rxDrop | output | 1 | One-cycle pulse for an invalid or too-fast speed byte |

## Verification
The bench runs the decoder with a capability of S200. This lets one run tell an accepted speed apart from one that is legal but too fast. Packets are sent with a multi-byte preamble, with no preamble, and straight out of a status cycle, which separates correct start detection from start detection that needs an idle cycle first. Speed bytes with their don't-care bits set check that the decoder masks exactly the right bits. The payload includes bytes with bit 7 set, which shows that preamble skipping stops once the speed byte is read. Preamble-only, payload-free and invalid-speed operations, and a reset in mid-packet, tell the null, end and drop paths apart.

// File: rtl/link_rx_pkg.sv
package link_rx_pkg;
  localparam int CTL_W  = 2;
  localparam int DATA_W = 8;
  localparam int SPD_W  = 2;

  localparam logic [CTL_W-1:0] CTL_IDLE   = 2'b00;
  localparam logic [CTL_W-1:0] CTL_STATUS = 2'b01;
  localparam logic [CTL_W-1:0] CTL_RECV   = 2'b10;

  typedef enum logic [SPD_W-1:0] {
    SPD_100 = 2'd0,
    SPD_200 = 2'd1,
    SPD_400 = 2'd2
  } speed_e;

  typedef struct packed {
    logic             legal;
    logic [SPD_W-1:0] code;
  } speedDec_t;

  // Control-to-datapath strobes, all valid for one cycle
  typedef struct packed {
    logic loadSpeed;
    logic emit;
    logic first;
    logic endPkt;
    logic endNull;
    logic drop;
  } strobe_t;

  function automatic speedDec_t decodeSpeed(input logic [DATA_W-1:0] b);
    speedDec_t r;
    r.legal = 1'b1;
    r.code  = SPD_100;
    if (b[7:6] == 2'b00)          r.code = SPD_100;
    else if (b[7:4] == 4'b0100)   r.code = SPD_200;
    else if (b == 8'b0101_0000)   r.code = SPD_400;
    else                          r.legal = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/link_rx_ctrl.sv
module link_rx_ctrl
  import link_rx_pkg::*;
#(
  parameter int MAX_SPEED = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CTL_W-1:0] ctlIn,
  input  logic             dataOn,
  input  speedDec_t        dec,
  output strobe_t          strb
);
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_FIRST,
    ST_BODY,
    ST_DISCARD
  } state_e;

  state_e state, stateNxt;
  logic   isRecv;
  logic   speedOk;

  assign isRecv  = (ctlIn == CTL_RECV);
  assign speedOk = dec.legal && (int'(dec.code) <= MAX_SPEED);

  always_comb begin
    strb     = '0;
    stateNxt = state;
    if (isRecv) begin
      unique case (state)
        ST_IDLE, ST_PRE: begin
          if (dataOn) begin
            stateNxt = ST_PRE;
          end else if (speedOk) begin
            strb.loadSpeed = 1'b1;
            stateNxt       = ST_FIRST;
          end else begin
            strb.drop = 1'b1;
            stateNxt  = ST_DISCARD;
          end
        end
        ST_FIRST: begin
          strb.emit  = 1'b1;
          strb.first = 1'b1;
          stateNxt   = ST_BODY;
        end
        ST_BODY: begin
          strb.emit = 1'b1;
        end
        default: begin
          stateNxt = ST_DISCARD;
        end
      endcase
    end else begin
      unique case (state)
        ST_PRE:            strb.endNull = 1'b1;
        ST_FIRST, ST_BODY: strb.endPkt  = 1'b1;
        default:           ;
      endcase
      stateNxt = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end
endmodule

// File: rtl/link_rx_dpath.sv
module link_rx_dpath
  import link_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] dataIn,
  output logic              dataOn,
  output speedDec_t         dec,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              rxSop,
  output logic              rxEop,
  output logic [SPD_W-1:0]  rxSpeed,
  output logic              nullPkt,
  output logic              rxDrop
);
  assign dataOn = dataIn[DATA_W-1];
  assign dec    = decodeSpeed(dataIn);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxValid <= 1'b0;
      rxData  <= '0;
      rxSop   <= 1'b0;
      rxEop   <= 1'b0;
      rxSpeed <= '0;
      nullPkt <= 1'b0;
      rxDrop  <= 1'b0;
    end else begin
      rxValid <= strb.emit;
      rxData  <= strb.emit ? dataIn : '0;
      rxSop   <= strb.first;
      rxEop   <= strb.endPkt;
      nullPkt <= strb.endNull;
      rxDrop  <= strb.drop;
      if (strb.loadSpeed) rxSpeed <= dec.code;
    end
  end
endmodule

// File: rtl/link_rx_decoder.sv
module link_rx_decoder
  import link_rx_pkg::*;
#(
  parameter int MAX_SPEED = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CTL_W-1:0]  ctlIn,
  input  logic [DATA_W-1:0] dataIn,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              rxSop,
  output logic              rxEop,
  output logic [SPD_W-1:0]  rxSpeed,
  output logic              nullPkt,
  output logic              rxDrop
);
  strobe_t   strb;
  speedDec_t dec;
  logic      dataOn;

  link_rx_ctrl #(.MAX_SPEED(MAX_SPEED)) ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .ctlIn  (ctlIn),
    .dataOn (dataOn),
    .dec    (dec),
    .strb   (strb)
  );

  link_rx_dpath dpath_i (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .dataIn  (dataIn),
    .dataOn  (dataOn),
    .dec     (dec),
    .rxValid (rxValid),
    .rxData  (rxData),
    .rxSop   (rxSop),
    .rxEop   (rxEop),
    .rxSpeed (rxSpeed),
    .nullPkt (nullPkt),
    .rxDrop  (rxDrop)
  );
endmodule

// File: rtl/link_rx_decoder_chk.sv
module link_rx_decoder_chk
  import link_rx_pkg::*;
#(
  parameter int MAX_SPEED = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic [CTL_W-1:0]  ctlIn,
  input logic [DATA_W-1:0] dataIn,
  input logic              rxValid,
  input logic [DATA_W-1:0] rxData,
  input logic              rxSop,
  input logic              rxEop,
  input logic [SPD_W-1:0]  rxSpeed,
  input logic              nullPkt,
  input logic              rxDrop
);
  // R1: one clock after reset, every pulse is low
  a_r1_reset_clears: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rstN) |-> !(rxValid || rxSop || rxEop || nullPkt || rxDrop) && rxSpeed == '0);

  // R5: start marker only on a valid byte
  a_r5_sop_has_valid: assert property (@(posedge clk) disable iff (!rstN)
    rxSop |-> rxValid);

  // R5: payload comes from a receive cycle, byte unchanged
  a_r5_payload_source: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> $past(ctlIn) == CTL_RECV && rxData == $past(dataIn));

  // R4: speed is stable inside a packet and within capability
  a_r4_speed_held: assert property (@(posedge clk) disable iff (!rstN)
    rxValid && !rxSop |-> $stable(rxSpeed));
  a_r9_speed_in_cap: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> int'(rxSpeed) <= MAX_SPEED);

  // R6: end pulse follows a non-receive cycle and lasts one cycle
  a_r6_eop_on_end: assert property (@(posedge clk) disable iff (!rstN)
    rxEop |-> $past(ctlIn) != CTL_RECV);
  a_r6_eop_single: assert property (@(posedge clk) disable iff (!rstN)
    rxEop |=> !rxEop);

  // R7: null pulse follows a non-receive cycle
  a_r7_null_on_end: assert property (@(posedge clk) disable iff (!rstN)
    nullPkt |-> $past(ctlIn) != CTL_RECV && !rxValid);

  // R8: drop comes from a receive byte that is not a data-on byte
  a_r8_drop_on_speed_byte: assert property (@(posedge clk) disable iff (!rstN)
    rxDrop |-> $past(ctlIn) == CTL_RECV && !$past(dataIn[DATA_W-1]));

  // R6 R7 R8: the three event pulses never coincide
  a_r8_events_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rxEop, nullPkt, rxDrop}));
endmodule

bind link_rx_decoder link_rx_decoder_chk #(.MAX_SPEED(MAX_SPEED)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .ctlIn   (ctlIn),
  .dataIn  (dataIn),
  .rxValid (rxValid),
  .rxData  (rxData),
  .rxSop   (rxSop),
  .rxEop   (rxEop),
  .rxSpeed (rxSpeed),
  .nullPkt (nullPkt),
  .rxDrop  (rxDrop)
);

// File: tb/link_rx_decoder_tb_top.sv
module link_rx_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] ctlIn = 2'b00;
  logic [7:0] dataIn = 8'h00;
  logic       rxValid, rxSop, rxEop, nullPkt, rxDrop;
  logic [7:0] rxData;
  logic [1:0] rxSpeed;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  link_rx_decoder #(.MAX_SPEED(1)) dut_i (
    .clk(clk), .rstN(rstN), .ctlIn(ctlIn), .dataIn(dataIn),
    .rxValid(rxValid), .rxData(rxData), .rxSop(rxSop), .rxEop(rxEop),
    .rxSpeed(rxSpeed), .nullPkt(nullPkt), .rxDrop(rxDrop)
  );

  typedef struct packed {
    logic [1:0] ctl;
    logic [7:0] din;
    logic       v;
    logic [7:0] d;
    logic       s;
    logic       e;
    logic       n;
    logic       dr;
    logic [1:0] sp;
    logic [7:0] req;
  } vec_t;

  // ctl, din, then outputs expected one clock later, then requirement number
  localparam vec_t VECS [0:NV-1] = '{
    '{2'b01, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd2}, // R2 status
    '{2'b10, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd3}, // R3 data-on
    '{2'b10, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd3}, // R3
    '{2'b10, 8'h43, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 8'd4}, // R4 S200
    '{2'b10, 8'hA5, 1'b1, 8'hA5, 1'b1, 1'b0, 1'b0, 1'b0, 2'd1, 8'd5}, // R5 sop
    '{2'b10, 8'h3C, 1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 8'd5}, // R5
    '{2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 8'd6}, // R6 eop
    '{2'b01, 8'h12, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 8'd2}, // R2 status
    '{2'b10, 8'h2A, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd2}, // R2 R4 S100 from status
    '{2'b10, 8'h80, 1'b1, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'd5}, // R5
    '{2'b10, 8'hFF, 1'b1, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd5}, // R5 bit7 as data
    '{2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 8'd6}, // R6
    '{2'b10, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd3}, // R3
    '{2'b10, 8'hFE, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd3}, // R3
    '{2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 2'd0, 8'd7}, // R7 null
    '{2'b10, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd3}, // R3
    '{2'b10, 8'h60, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 8'd8}, // R8 invalid
    '{2'b10, 8'h11, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd8}, // R8 discarded
    '{2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd8}, // R8 no eop
    '{2'b10, 8'h51, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 8'd8}, // R8 near S400
    '{2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd8}, // R8
    '{2'b10, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd3}, // R3
    '{2'b10, 8'h50, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 2'd0, 8'd9}, // R9 S400 too fast
    '{2'b10, 8'h22, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd9}, // R9 discarded
    '{2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd9}, // R9 no eop
    '{2'b10, 8'hFF, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd3}, // R3
    '{2'b10, 8'h4F, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 8'd4}, // R4 don't-cares set
    '{2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 8'd6}, // R6 empty packet
    '{2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 8'd6}, // R6 single pulse
    '{2'b10, 8'h3F, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 8'd4}, // R4 S100 all x set
    '{2'b10, 8'h00, 1'b1, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 8'd5}, // R5
    '{2'b00, 8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 8'd6}  // R6
  };

  task automatic chk(input string tag, input logic v, input logic [7:0] d,
                     input logic s, input logic e, input logic n,
                     input logic dr, input logic [1:0] sp);
    logic [14:0] act, exp;
    act = {rxValid, rxData, rxSop, rxEop, nullPkt, rxDrop, rxSpeed};
    exp = {v, d, s, e, n, dr, sp};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got v=%0b d=%02h sop=%0b eop=%0b null=%0b drop=%0b spd=%0d, expected v=%0b d=%02h sop=%0b eop=%0b null=%0b drop=%0b spd=%0d",
               tag, act[14], act[13:6], act[5], act[4], act[3], act[2], act[1:0],
               v, d, s, e, n, dr, sp);
    end
  endtask

  task automatic step(input logic [1:0] c, input logic [7:0] b);
    @(negedge clk);
    ctlIn  = c;
    dataIn = b;
    @(posedge clk);
    #1;
  endtask

  initial begin
    // R1 reset state
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset state", 0, 8'h00, 0, 0, 0, 0, 2'd0);
    @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VECS[i].ctl, VECS[i].din);
      chk($sformatf("R%0d vector %0d", VECS[i].req, i),
          VECS[i].v, VECS[i].d, VECS[i].s, VECS[i].e, VECS[i].n,
          VECS[i].dr, VECS[i].sp);
    end

    // R1: reset in mid-packet
    step(2'b10, 8'hFF);
    step(2'b10, 8'h40);
    chk("R4 S200 before reset", 0, 8'h00, 0, 0, 0, 0, 2'd1);
    step(2'b10, 8'h12);
    chk("R5 byte before reset", 1, 8'h12, 1, 0, 0, 0, 2'd1);
    @(negedge clk);
    rstN   = 1'b0;
    ctlIn  = 2'b10;
    dataIn = 8'h99;
    @(posedge clk);
    #1;
    chk("R1 mid-packet reset", 0, 8'h00, 0, 0, 0, 0, 2'd0);
    @(negedge clk);
    rstN  = 1'b1;
    ctlIn = 2'b00;
    @(posedge clk);
    #1;
    chk("R1 no eop after reset", 0, 8'h00, 0, 0, 0, 0, 2'd0);
    // decoder must treat 0x55 as a fresh (invalid) speed byte
    step(2'b10, 8'h55);
    chk("R1 R8 fresh decode after reset", 0, 8'h00, 0, 0, 0, 1, 2'd0);
    step(2'b00, 8'h00);
    chk("R8 no end after drop", 0, 8'h00, 0, 0, 0, 0, 2'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule